// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block turns one multi-register transfer instruction into an ordered stream of single-word micro-operation descriptors. A one-cycle `start` pulse captures a register list, the pre/post and up/down addressing bits, the writeback and load bits, a base register index and a 4-bit condition code. The block then presents one descriptor at a time on a valid/ready output and moves to the next one on every accepted handshake.

Every stream opens with a base-copy micro-op: an add of zero to the base register. One transfer micro-op follows for each set bit of the list, visited from the lowest index upward. Each transfer carries a byte-offset magnitude and an add/subtract flag. The offset starts at a value fixed by the addressing mode and moves by 4 after each transfer. When writeback is requested, a final micro-op moves the base register past the whole transferred block. The block only produces descriptors. Memory access, register reads and writes, and condition evaluation all happen downstream.

The control is a four-state machine:
- `S_IDLE` waits for `start`.
- `S_COPY` presents the base copy.
- `S_XFER` presents the transfers.
- `S_WBACK` presents the writeback.

The transitions are:
- `S_IDLE`→`S_COPY` on a start with a non-empty list.
- `S_COPY`→`S_XFER` on acceptance.
- `S_XFER`→`S_XFER` on acceptance while list bits remain.
- `S_XFER`→`S_WBACK` on acceptance of the last transfer with writeback enabled.
- `S_XFER`→`S_IDLE` on acceptance of the last transfer without writeback.
- `S_WBACK`→`S_IDLE` on acceptance.
- Any state→`S_IDLE` on synchronous reset.

Top module: `lsm_uop_seq`

## Requirements
- R1: After a synchronous reset, `uop_valid`, `busy` and `err` are 0.
- R2: A start with an all-zero list leaves the block idle and emits no micro-op. `err` is high for exactly the one cycle after that start.
- R3: The first micro-op after a start has kind 0 (base copy). Its `uop_reg` is the base index, its offset is 0 and `uop_add` is 1. It appears in the cycle after the start.
- R4: Let n be the number of set list bits. The first transfer offset depends on {pre_idx, up_dir}: 4n-4 for 00, 0 for 01, 4n for 10 and 4 for 11.
- R5: Each later transfer offset is the previous one plus 4 when `up_dir` is 1, or minus 4 when it is 0.
- R6: Exactly n transfer micro-ops (kind 1) are emitted. Their `uop_reg` values are the set list bit indices in ascending order.
- R7: On transfers, `uop_add` equals `up_dir` and `uop_load` equals `is_load`. On copy and writeback micro-ops, `uop_load` is 0.
- R8: When `wb_en` is 1, a final micro-op of kind 2 follows the transfers. It carries the base index, offset 4n and `uop_add` equal to `up_dir`. When `wb_en` is 0, no kind 2 micro-op is emitted.
- R9: Every micro-op of a stream carries the condition code captured at start on `uop_cond`.
- R10: While `uop_valid` is high and `uop_ready` is low, every descriptor output holds its value into the next cycle.
- R11: `uop_last` is 1 on the final micro-op of a stream and 0 on all others. `uop_valid` is 0 in the cycle after that micro-op is accepted.
- R12: A `start` while `busy` is 1 has no effect on the stream in progress.
- R13: A synchronous reset during a stream drops it. `uop_valid` and `busy` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a stream |
| reg_list | input | 16 | Register list, bit i selects register i |
| pre_idx | input | 1 | Offset applied before the access (1) or after it (0) |
| up_dir | input | 1 | Offsets added (1) or subtracted (0) |
| wb_en | input | 1 | Append a base writeback micro-op |
| is_load | input | 1 | Transfers are loads (1) or stores (0) |
| base_idx | input | 4 | Base register index |
| cond_in | input | 4 | Condition code copied onto every micro-op |
| uop_ready | input | 1 | Consumer accepts the current micro-op |
| uop_valid | output | 1 | A micro-op descriptor is presented |
| uop_kind | output | 2 | 0 base copy, 1 transfer, 2 writeback |
| uop_reg | output | 4 | Register index of the micro-op |
| uop_offset | output | 7 | Byte offset magnitude |
| uop_add | output | 1 | Offset is added (1) or subtracted (0) |
| uop_load | output | 1 | Transfer is a load |
| uop_cond | output | 4 | Captured condition code |
| uop_last | output | 1 | This is the final micro-op of the stream |
| busy | output | 1 | A stream is in progress |
| err | output | 1 | One-cycle flag for a start with an empty list |

## Verification
The hardest situations to reach are a start that arrives while a stream is still being drained and a reset that lands mid-stream, because both depend on exact cycle placement relative to the handshake. The bench injects a second start with a different list a couple of cycles into a stream, while `uop_ready` toggles in an irregular pattern. A reference queue, built only from the requirements, then shows whether the stream changed. A reset is also raised after a few transfers of a long stream, and a clean stream run afterwards confirms that no stale list bits or offset survived. All four addressing modes are covered, with single-bit, sparse and full lists and both writeback settings.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        UOP_BASECOPY = 2'd0,
        UOP_XFER     = 2'd1,
        UOP_WBACK    = 2'd2
    } uop_kind_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COPY  = 2'd1,
        S_XFER  = 2'd2,
        S_WBACK = 2'd3
    } seq_state_t;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int N = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] count
);
    logic [CW-1:0] partial [N+1];

    assign partial[0] = '0;
    for (genvar g = 0; g < N; g++) begin : g_acc
        assign partial[g+1] = partial[g] + CW'(vec[g]);
    end
    assign count = partial[N];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int N = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsm_start_off.sv
module lsm_start_off #(
    parameter int CW = 5,
    parameter int OFFW = CW + 2
) (
    input  logic            pre,
    input  logic            up,
    input  logic [CW-1:0]   cnt,
    output logic [OFFW-1:0] off
);
    logic [OFFW-1:0] span;

    assign span = {cnt, 2'b00};

    always_comb begin
        unique case ({pre, up})
            2'b00:   off = span - OFFW'(4);   // decrement, access after
            2'b01:   off = '0;                // increment, access after
            2'b10:   off = span;              // decrement, access before
            default: off = OFFW'(4);          // increment, access before
        endcase
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int CONDW = 4,
    localparam int IW   = $clog2(NREGS),
    localparam int CW   = $clog2(NREGS + 1),
    localparam int OFFW = CW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NREGS-1:0] reg_list,
    input  logic             pre_idx,
    input  logic             up_dir,
    input  logic             wb_en,
    input  logic             is_load,
    input  logic [IW-1:0]    base_idx,
    input  logic [CONDW-1:0] cond_in,
    input  logic             uop_ready,
    output logic             uop_valid,
    output logic [1:0]       uop_kind,
    output logic [IW-1:0]    uop_reg,
    output logic [OFFW-1:0]  uop_offset,
    output logic             uop_add,
    output logic             uop_load,
    output logic [CONDW-1:0] uop_cond,
    output logic             uop_last,
    output logic             busy,
    output logic             err
);
    seq_state_t        state_q;
    logic [NREGS-1:0]  rem_q;
    logic [NREGS-1:0]  rem_next;
    logic [NREGS-1:0]  pick_mask;
    logic [OFFW-1:0]   off_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     base_q;
    logic [CONDW-1:0]  cond_q;
    logic              up_q;
    logic              wb_q;
    logic              ld_q;
    logic              err_q;

    logic [CW-1:0]     in_cnt;
    logic [OFFW-1:0]   in_off;
    logic [IW-1:0]     pick_idx;
    logic              pick_found;
    logic              fire;

    lsm_popcnt #(.N(NREGS), .CW(CW)) u_cnt (
        .vec   (reg_list),
        .count (in_cnt)
    );

    lsm_start_off #(.CW(CW), .OFFW(OFFW)) u_off (
        .pre (pre_idx),
        .up  (up_dir),
        .cnt (in_cnt),
        .off (in_off)
    );

    lsm_lowbit #(.N(NREGS), .IW(IW)) u_pick (
        .vec   (rem_q),
        .idx   (pick_idx),
        .found (pick_found)
    );

    always_comb begin
        pick_mask           = '0;
        pick_mask[pick_idx] = 1'b1;
        rem_next            = rem_q & ~pick_mask;
    end

    assign fire = uop_valid && uop_ready;

    // State and context registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            rem_q   <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
            base_q  <= '0;
            cond_q  <= '0;
            up_q    <= 1'b0;
            wb_q    <= 1'b0;
            ld_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (reg_list == '0) begin
                            err_q <= 1'b1;
                        end else begin
                            rem_q   <= reg_list;
                            cnt_q   <= in_cnt;
                            off_q   <= in_off;
                            base_q  <= base_idx;
                            cond_q  <= cond_in;
                            up_q    <= up_dir;
                            wb_q    <= wb_en;
                            ld_q    <= is_load;
                            state_q <= S_COPY;
                        end
                    end
                end
                S_COPY: begin
                    if (fire) state_q <= S_XFER;
                end
                S_XFER: begin
                    if (fire) begin
                        rem_q <= rem_next;
                        off_q <= up_q ? off_q + OFFW'(4) : off_q - OFFW'(4);
                        if (rem_next == '0)
                            state_q <= wb_q ? S_WBACK : S_IDLE;
                    end
                end
                S_WBACK: begin
                    if (fire) state_q <= S_IDLE;
                end
            endcase
        end
    end

    // Descriptor outputs
    always_comb begin
        uop_valid  = 1'b0;
        uop_kind   = UOP_BASECOPY;
        uop_reg    = base_q;
        uop_offset = '0;
        uop_add    = 1'b1;
        uop_load   = 1'b0;
        uop_last   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                uop_valid = 1'b0;
            end
            S_COPY: begin
                uop_valid = 1'b1;
            end
            S_XFER: begin
                uop_valid  = pick_found;
                uop_kind   = UOP_XFER;
                uop_reg    = pick_idx;
                uop_offset = off_q;
                uop_add    = up_q;
                uop_load   = ld_q;
                uop_last   = (rem_next == '0) && !wb_q;
            end
            S_WBACK: begin
                uop_valid  = 1'b1;
                uop_kind   = UOP_WBACK;
                uop_offset = {cnt_q, 2'b00};
                uop_add    = up_q;
                uop_last   = 1'b1;
            end
        endcase
    end

    assign uop_cond = cond_q;
    assign busy     = (state_q != S_IDLE);
    assign err      = err_q;
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk
    import lsm_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int IW   = $clog2(NREGS),
    localparam int CW   = $clog2(NREGS + 1),
    localparam int OFFW = CW + 2
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            uop_ready,
    input logic            uop_valid,
    input logic [1:0]      uop_kind,
    input logic [IW-1:0]   uop_reg,
    input logic [OFFW-1:0] uop_offset,
    input logic            uop_add,
    input logic            uop_load,
    input logic            uop_last,
    input logic            busy,
    input logic            err
);
    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        err |-> !uop_valid && !busy);

    assert_copy_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_kind == UOP_BASECOPY) |-> (uop_offset == '0) && uop_add && !uop_load);

    assert_step_four_R5: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && uop_kind == UOP_XFER) |=>
            (!uop_valid || uop_kind != UOP_XFER ||
             (uop_add ? uop_offset == $past(uop_offset) + OFFW'(4)
                      : uop_offset == $past(uop_offset) - OFFW'(4))));

    assert_ascending_R6: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && uop_kind == UOP_XFER) |=>
            (!uop_valid || uop_kind != UOP_XFER || uop_reg > $past(uop_reg)));

    assert_wback_store_R8: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_kind == UOP_WBACK) |-> uop_last && !uop_load);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready) |=>
            (uop_valid && $stable(uop_kind) && $stable(uop_reg) && $stable(uop_offset)
             && $stable(uop_add) && $stable(uop_load) && $stable(uop_last)));

    assert_last_ends_R11: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && uop_last) |=> !uop_valid && !busy);

    assert_busy_start_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !err);
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.NREGS(NREGS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .uop_ready  (uop_ready),
    .uop_valid  (uop_valid),
    .uop_kind   (uop_kind),
    .uop_reg    (uop_reg),
    .uop_offset (uop_offset),
    .uop_add    (uop_add),
    .uop_load   (uop_load),
    .uop_last   (uop_last),
    .busy       (busy),
    .err        (err)
);

// File: tb/lsm_uop_seq_tb_top.sv
module lsm_uop_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] reg_list = '0;
    logic        pre_idx = 1'b0;
    logic        up_dir = 1'b0;
    logic        wb_en = 1'b0;
    logic        is_load = 1'b0;
    logic [3:0]  base_idx = '0;
    logic [3:0]  cond_in = '0;
    logic        uop_ready = 1'b0;
    logic        uop_valid;
    logic [1:0]  uop_kind;
    logic [3:0]  uop_reg;
    logic [6:0]  uop_offset;
    logic        uop_add;
    logic        uop_load;
    logic [3:0]  uop_cond;
    logic        uop_last;
    logic        busy;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int kind;
        int rg;
        int off;
        bit add;
        bit ld;
        bit last;
    } exp_t;

    exp_t q[$];
    int   exp_cond;

    always #2 clk = ~clk;   // 250 MHz

    lsm_uop_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .reg_list(reg_list),
        .pre_idx(pre_idx), .up_dir(up_dir), .wb_en(wb_en), .is_load(is_load),
        .base_idx(base_idx), .cond_in(cond_in), .uop_ready(uop_ready),
        .uop_valid(uop_valid), .uop_kind(uop_kind), .uop_reg(uop_reg),
        .uop_offset(uop_offset), .uop_add(uop_add), .uop_load(uop_load),
        .uop_cond(uop_cond), .uop_last(uop_last), .busy(busy), .err(err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Reference stream built from R3 R4 R5 R6 R7 R8 R11
    task automatic build(input logic [15:0] lst, input bit p, input bit u,
                         input bit w, input bit l, input int b);
        int n;
        int off;
        exp_t e;
        n = 0;
        for (int i = 0; i < 16; i++) if (lst[i]) n++;
        if (!p && !u)     off = 4 * n - 4;
        else if (!p && u) off = 0;
        else if (p && !u) off = 4 * n;
        else              off = 4;
        q.delete();
        e = '{kind: 0, rg: b, off: 0, add: 1'b1, ld: 1'b0, last: 1'b0};
        q.push_back(e);
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                e = '{kind: 1, rg: i, off: off, add: u, ld: l, last: 1'b0};
                q.push_back(e);
                off = u ? off + 4 : off - 4;
            end
        end
        if (w) begin
            e = '{kind: 2, rg: b, off: 4 * n, add: u, ld: 1'b0, last: 1'b0};
            q.push_back(e);
        end
        q[q.size() - 1].last = 1'b1;
    endtask

    function automatic string tag_of(input int kind);
        if (kind == 0)      return "R3";
        else if (kind == 1) return "R6";
        else                return "R8";
    endfunction

    // patt: 0 always ready, 1 irregular ready; inj: start again while busy (R12)
    task automatic run_seq(input logic [15:0] lst, input bit p, input bit u,
                           input bit w, input bit l, input logic [3:0] b,
                           input logic [3:0] c, input bit patt, input bit inj);
        int step;
        exp_t h;
        @(negedge clk);
        reg_list = lst; pre_idx = p; up_dir = u; wb_en = w; is_load = l;
        base_idx = b; cond_in = c; start = 1'b1;
        build(lst, p, u, w, l, int'(b));
        exp_cond = int'(c);
        @(negedge clk);
        start = 1'b0;
        step = 0;
        while (q.size() > 0 && step < 400) begin
            uop_ready = patt ? (((step * 5 + 3) % 7) < 4) : 1'b1;
            if (inj && step == 2) begin
                start = 1'b1; reg_list = 16'h00F0; up_dir = ~u; base_idx = ~b; cond_in = ~c;
            end else begin
                start = 1'b0;
            end
            h = q[0];
            chk(uop_valid == 1'b1, "R3 valid in stream", int'(uop_valid), 1);
            chk(int'(uop_kind) == h.kind, tag_of(h.kind), int'(uop_kind), h.kind);
            chk(int'(uop_reg) == h.rg, "R6 reg", int'(uop_reg), h.rg);
            chk(int'(uop_offset) == h.off, "R4 R5 offset", int'(uop_offset), h.off);
            chk(uop_add == h.add, "R7 add", int'(uop_add), int'(h.add));
            chk(uop_load == h.ld, "R7 load", int'(uop_load), int'(h.ld));
            chk(uop_last == h.last, "R11 last", int'(uop_last), int'(h.last));
            chk(int'(uop_cond) == exp_cond, "R9 cond", int'(uop_cond), exp_cond);
            if (uop_valid && uop_ready) void'(q.pop_front());   // R10: held until popped
            step++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(uop_valid == 1'b0, "R11 idle after last", int'(uop_valid), 0);
        chk(busy == 1'b0, "R11 busy after last", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        chk(uop_valid == 1'b0, "R1 valid", int'(uop_valid), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(err == 1'b0, "R1 err", int'(err), 0);

        // R4 all four modes, R8 with and without writeback
        run_seq(16'h00A5, 1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 4'hE, 1'b0, 1'b0);
        run_seq(16'h8001, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2,  4'h1, 1'b1, 1'b0);
        run_seq(16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 4'd15, 4'h7, 1'b1, 1'b0);
        run_seq(16'h0010, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'hA, 1'b0, 1'b0);
        run_seq(16'h8000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  4'h3, 1'b1, 1'b0);
        run_seq(16'h1248, 1'b1, 1'b1, 1'b0, 1'b0, 4'd9,  4'hC, 1'b1, 1'b0);

        // R2 empty list
        @(negedge clk);
        reg_list = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R2 err set", int'(err), 1);
        chk(uop_valid == 1'b0, "R2 no uop", int'(uop_valid), 0);
        @(negedge clk);
        chk(err == 1'b0, "R2 err single cycle", int'(err), 0);
        chk(uop_valid == 1'b0 && busy == 1'b0, "R2 still idle", int'(busy), 0);

        // R12 start while busy
        run_seq(16'h0F00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6, 4'h5, 1'b1, 1'b1);

        // R13 reset mid-stream
        @(negedge clk);
        reg_list = 16'hFFFF; pre_idx = 1'b0; up_dir = 1'b1; wb_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; uop_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(uop_valid == 1'b0, "R13 valid after reset", int'(uop_valid), 0);
        chk(busy == 1'b0, "R13 busy after reset", int'(busy), 0);
        run_seq(16'h0003, 1'b1, 1'b0, 1'b1, 1'b0, 4'd11, 4'h2, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule